// File: doc/BRIEF.md
# Oversampling Fractional Baud Generator

This block derives the two timing strobes a UART receiver and transmitter need from one source clock. One strobe fires once per oversampling period, sixteen times per bit. The other fires once per bit. An integer prescaler sets the base length of each oversampling period in source-clock cycles. Two small modulation stages then add single cycles at fixed places, which gives a fractional division ratio without a wide accumulator.

The first stage uses a 4-bit fine setting. It picks a fixed set of oversampling slots inside every bit and makes each of them one source cycle longer. The set grows symmetrically from both ends of the bit, so the added cycles spread evenly across the bit. The second stage uses an 8-bit pattern that a rotating bit counter indexes. When the selected pattern bit is 1, the last slot of that bit gets one more cycle.

Configuration is captured only when the block starts and at bit boundaries. Software can therefore change it at any time without producing a malformed period. The block also drives the index of the current slot, so downstream sampling logic can find the mid-bit slots.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, `tick16` and `bit_tick` are 0 and `slot_idx` is 0.
- R2: While `en` is low, neither tick is produced, `slot_idx` reads 0, and the slot and bit counters are held at 0.
- R3: An unstretched oversampling period lasts `presc` source cycles. A `presc` value of 0 is treated as 1. A period ends in the cycle in which `tick16` is high for one cycle.
- R4: `slot_idx` gives the slot that is in progress. It steps 0,1,…,15 and then returns to 0. `bit_tick` is high for one cycle, together with `tick16`, exactly when slot 15 ends.
- R5: With fine setting F, slot s is stretched by one cycle when it appears among the first F entries of the order 1,15,2,14,3,13,4,12,5,11,6,10,7,9,8. Slot 0 is never stretched.
- R6: A bit lasts 16·max(presc,1) + F + b source cycles, where b is the second-stage bit that applies to that bit.
- R7: A 3-bit bit counter starts at 0 when the block is enabled and increments at every bit boundary, wrapping from 7 to 0. When `bit_pat[counter]` is 1, slot 15 of that bit is one cycle longer.
- R8: `presc`, `fine_sel` and `bit_pat` are captured at the first enabled cycle and at each bit boundary. A change in the middle of a bit affects only the next bit.
- R9: Driving `en` low and then high again restarts at slot 0 with the bit counter at 0. The first `tick16` comes after the slot-0 length, counted in rising edges from the first edge at which `en` is seen high.
- R10: With `presc`=1, `fine_sel`=0 and `bit_pat`=0, `tick16` is high in every cycle and `bit_tick` is high in every 16th cycle. This is the fastest rate, one sixteenth of the source clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds all counters at 0 |
| presc | input | PRESC_W | Base oversampling period in source cycles (0 acts as 1) |
| fine_sel | input | 4 | First-stage stretch count, 0 to 15 |
| bit_pat | input | PAT_W | Second-stage per-bit stretch pattern |
| tick16 | output | 1 | One-cycle strobe at the end of each oversampling period |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit |
| slot_idx | output | 4 | Oversampling slot in progress within the bit |

## Verification
The bench measures every oversampling period in source cycles and compares it with a slot-order model that it builds itself. It does this for all sixteen fine settings, several prescaler values including 0, and patterns that need the bit counter to wrap. A wrong stretch order would show up as a period that is one cycle off in a specific slot, even when the total bit length is correct. Putting the second-stage cycle in the wrong slot, or indexing the pattern wrongly, would make slot 15 or the bit sum wrong. The directed cases check the following: a configuration change in the middle of a bit must not leak into the current bit; a restart after disable must start again from slot 0 and pattern bit 0; and at the fastest rate, a wrong terminal count would drop ticks.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int SLOTS  = 16;
  localparam int SLOT_W = 4;

  // Position of slot s (1..15) in the stretch fill order: slots are taken
  // alternately from the front and the back of the bit.
  function automatic int stretch_rank(input int s);
    if (s <= 8) return 2 * (s - 1);
    return 2 * (15 - s) + 1;
  endfunction

  // True when slot s is stretched under fine setting fsel.
  function automatic logic slot_stretched(input logic [SLOT_W-1:0] fsel, input int s);
    if (s == 0) return 1'b0;
    return stretch_rank(s) < int'(fsel);
  endfunction
endpackage

// File: rtl/fbg_stretch_map.sv
module fbg_stretch_map
  import fbg_pkg::*;
(
  input  logic [SLOT_W-1:0] fsel,
  output logic [SLOTS-1:0]  mask
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign mask[g] = slot_stretched(fsel, g);
  end
endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt #(
  parameter int LW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [LW-1:0] len,
  output logic          last
);
  logic [LW-1:0] cnt;

  assign last = active && (cnt == len - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!active || last) cnt <= '0;
    else                     cnt <= cnt + LW'(1);
  end
endmodule

// File: rtl/fbg_slot_seq.sv
module fbg_slot_seq
  import fbg_pkg::*;
#(
  parameter int BCW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot,
  output logic [BCW-1:0]    bitcnt,
  output logic              bit_end
);
  assign bit_end = adv && (slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      bitcnt <= '0;
    end else if (!active) begin
      slot   <= '0;
      bitcnt <= '0;
    end else if (adv) begin
      slot <= slot + SLOT_W'(1);
      if (bit_end) bitcnt <= bitcnt + BCW'(1);
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int PRESC_W = 16,
  parameter int PAT_W   = 8   // power of two, at least 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PRESC_W-1:0] presc,
  input  logic [SLOT_W-1:0]  fine_sel,
  input  logic [PAT_W-1:0]   bit_pat,
  output logic               tick16,
  output logic               bit_tick,
  output logic [SLOT_W-1:0]  slot_idx
);
  localparam int BCW = $clog2(PAT_W);
  localparam int LW  = PRESC_W + 1;

  // Slot length: base prescale (0 acts as 1) plus the two stretch cycles.
  function automatic logic [LW-1:0] slot_len(input logic [PRESC_W-1:0] p,
                                             input logic st1, input logic st2);
    logic [LW-1:0] base;
    base = (p == '0) ? LW'(1) : LW'(p);
    return base + LW'(st1) + LW'(st2);
  endfunction

  logic               run_q;
  logic [PRESC_W-1:0] p_sh;
  logic [SLOT_W-1:0]  f_sh;
  logic [PAT_W-1:0]   pat_sh;

  logic               active, start_load;
  logic [SLOTS-1:0]   mask;
  logic [SLOT_W-1:0]  slot;
  logic [BCW-1:0]     bitcnt;
  logic               bit_end, period_end;
  logic               stretch_now, tail_now;
  logic [LW-1:0]      cur_len;

  assign active      = run_q & en;
  assign start_load  = en & ~run_q;
  assign stretch_now = mask[slot];
  assign tail_now    = (slot == SLOT_W'(SLOTS - 1)) && pat_sh[bitcnt];
  assign cur_len     = slot_len(p_sh, stretch_now, tail_now);

  fbg_stretch_map u_map (
    .fsel (f_sh),
    .mask (mask)
  );

  fbg_period_cnt #(.LW(LW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .len    (cur_len),
    .last   (period_end)
  );

  fbg_slot_seq #(.BCW(BCW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .adv     (period_end),
    .slot    (slot),
    .bitcnt  (bitcnt),
    .bit_end (bit_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      p_sh   <= '0;
      f_sh   <= '0;
      pat_sh <= '0;
    end else begin
      run_q <= en;
      if (start_load || bit_end) begin
        p_sh   <= presc;
        f_sh   <= fine_sel;
        pat_sh <= bit_pat;
      end
    end
  end

  assign tick16   = period_end;
  assign bit_tick = bit_end;
  assign slot_idx = active ? slot : '0;
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       tick16,
  input logic       bit_tick,
  input logic [3:0] slot_idx,
  input logic       stretch_now
);
  a_r4_bit_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (tick16 && slot_idx == 4'd15));

  a_r4_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && slot_idx != 4'd15) |=> (!en || slot_idx == $past(slot_idx) + 4'd1));

  a_r4_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (slot_idx == 4'd0));

  a_r4_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick16) |=> (!en || $stable(slot_idx)));

  a_r4_bit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!tick16 && !bit_tick));

  a_r5_slot0_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slot_idx == 4'd0) |-> !stretch_now);
endmodule

bind frac_baud_gen fbg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .tick16      (tick16),
  .bit_tick    (bit_tick),
  .slot_idx    (slot_idx),
  .stretch_now (stretch_now)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] presc = '0;
  logic [3:0]  fine_sel = '0;
  logic [7:0]  bit_pat = '0;
  logic        tick16, bit_tick;
  logic [3:0]  slot_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ord [15];

  always #2.5ns clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .presc(presc), .fine_sel(fine_sel),
    .bit_pat(bit_pat), .tick16(tick16), .bit_tick(bit_tick), .slot_idx(slot_idx)
  );

  // {presc[15:0], fine_sel[3:0], bit_pat[7:0]}
  localparam logic [27:0] VEC [20] = '{
    {16'd1, 4'd0,  8'h00}, {16'd1, 4'd1,  8'h00}, {16'd2, 4'd2,  8'h00},
    {16'd3, 4'd3,  8'hA5}, {16'd1, 4'd4,  8'h00}, {16'd2, 4'd5,  8'h01},
    {16'd4, 4'd6,  8'h80}, {16'd1, 4'd7,  8'hFF}, {16'd2, 4'd8,  8'h00},
    {16'd3, 4'd9,  8'h3C}, {16'd1, 4'd10, 8'h00}, {16'd2, 4'd11, 8'h55},
    {16'd3, 4'd12, 8'h00}, {16'd1, 4'd13, 8'h0F}, {16'd2, 4'd14, 8'h00},
    {16'd4, 4'd15, 8'hFF}, {16'd0, 4'd5,  8'h00}, {16'd5, 4'd15, 8'hAA},
    {16'd1, 4'd15, 8'h00}, {16'd7, 4'd0,  8'hC3}
  };

  function automatic int eff_p(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  // Slot s is stretched when it is among the first f entries of ord.
  function automatic int model_st(input int f, input int s);
    for (int k = 0; k < f; k++) if (ord[k] == s) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called just after a negedge; counts rising edges until tick16 is seen.
  task automatic meas(input int exp_len, input int exp_slot, input bit exp_last,
                      input string tag, output int got);
    int  n = 0;
    bit  seen = 1'b0;
    while (!seen && n < exp_len + 4) begin
      @(posedge clk); @(negedge clk);
      n++;
      seen = tick16;
    end
    got = n;
    chk(seen && n == exp_len, {tag, " period length"}, n, exp_len);
    chk(slot_idx == 4'(exp_slot), "R4 slot index", int'(slot_idx), exp_slot);
    chk(bit_tick == exp_last, "R4 bit tick at slot 15", int'(bit_tick), int'(exp_last));
  endtask

  task automatic run_bits(input int p, input int f, input int pat, input int bit0,
                          input int nbits, input int first_slot, input string tag);
    for (int b = 0; b < nbits; b++) begin
      int sum = 0;
      int s0 = (b == 0) ? first_slot : 0;
      int tail = (pat >> ((bit0 + b) % 8)) & 1;
      for (int s = s0; s < 16; s++) begin
        int got;
        int len = eff_p(p) + model_st(f, s) + ((s == 15) ? tail : 0);
        meas(len, s, s == 15, tag, got);
        sum += got;
      end
      if (s0 == 0)
        chk(sum == 16 * eff_p(p) + f + tail, "R6 bit length", sum, 16 * eff_p(p) + f + tail);
    end
  endtask

  initial begin
    int cnt;
    int got;
    for (int k = 0; k < 15; k++)
      ord[k] = (k % 2 == 0) ? (k / 2 + 1) : (15 - (k - 1) / 2);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(tick16 == 1'b0 && bit_tick == 1'b0, "R1 ticks in reset", int'(tick16), 0);
    chk(slot_idx == 4'd0, "R1 slot in reset", int'(slot_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tick16 == 1'b0 && slot_idx == 4'd0, "R1 idle after reset", int'(tick16), 0);

    // Table walk: R3 R5 R6 R7 over all fine settings
    for (int i = 0; i < 20; i++) begin
      {presc, fine_sel, bit_pat} = VEC[i];
      en = 1'b1;
      run_bits(int'(VEC[i][27:12]), int'(VEC[i][11:8]), int'(VEC[i][7:0]), 0, 9, 0, "R3 R5 R7");
      en = 1'b0;
      @(negedge clk);
    end

    // R2: disabled, no ticks
    presc = 16'd1; fine_sel = 4'd0; bit_pat = 8'h00;
    cnt = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (tick16 || bit_tick || slot_idx != 4'd0) cnt++;
    end
    chk(cnt == 0, "R2 activity while disabled", cnt, 0);

    // R10: fastest rate
    en = 1'b1;
    cnt = 0;
    for (int c = 1; c <= 48; c++) begin
      @(negedge clk);
      if (tick16 && (bit_tick == (c % 16 == 0))) cnt++;
    end
    chk(cnt == 48, "R10 full-rate cycles with correct ticks", cnt, 48);
    en = 1'b0;
    @(negedge clk);

    // R8: change configuration mid-bit
    presc = 16'd3; fine_sel = 4'd2; bit_pat = 8'h00;
    en = 1'b1;
    meas(3, 0, 1'b0, "R8 first slot", got);
    presc = 16'd5; fine_sel = 4'd0; bit_pat = 8'hFF;
    run_bits(3, 2, 0, 0, 1, 1, "R8 old config kept");
    run_bits(5, 0, 255, 1, 1, 0, "R8 new config");
    en = 1'b0;
    @(negedge clk);

    // R9: restart after disable mid-bit
    presc = 16'd2; fine_sel = 4'd3; bit_pat = 8'h01;
    en = 1'b1;
    run_bits(2, 3, 1, 0, 2, 0, "R7 pre-restart");
    for (int s = 0; s < 5; s++) meas(2 + model_st(3, s), s, 1'b0, "R9 partial bit", got);
    en = 1'b0;
    cnt = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (tick16 || bit_tick) cnt++;
    end
    chk(cnt == 0, "R2 no ticks after mid-bit disable", cnt, 0);
    en = 1'b1;
    run_bits(2, 3, 1, 0, 1, 0, "R9 restart");
    en = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule